// File: doc/BRIEF.md
# Serial EEPROM Transaction Master

This block is a two-wire bus master that carries out complete memory-device transactions on its own. A host hands it one command through a parallel interface: direction, a 7-bit device address, a memory address of one or two bytes, and a byte count. The block then produces every bus phase without further help. These phases are start, address frame, memory address, data frames, acknowledge slots, repeated start and stop. It asks the host for each outgoing byte with a one-cycle request pulse. It hands each incoming byte back with a one-cycle valid pulse.

Both bus lines are open drain. The block only pulls a line low through an enable, or releases it. SCL comes from a divider of the system clock. Each bit is split into four quarter phases: two with SCL low, then two with SCL high. A read is always a random read. The block writes the memory address, then issues a repeated start and switches direction. If the slave refuses a byte, the block raises a sticky error and closes the bus with a stop.

Top module: `eeprom_i2c_master`

## Requirements
- R1: After reset and whenever `busy` is low, both `scl_oe` and `sda_oe` are 0 (lines released), and `nack_err`, `rd_valid` and `wr_req` are 0 after reset.
- R2: SDA changes only while SCL is low, except at a start and a stop. A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. Each transaction begins with a start and ends with exactly one stop.
- R3: Every frame has 9 SCL pulses: 8 data bits, most significant first, then an acknowledge bit. The first frame after a start is the device address followed by a direction bit, where 0 means write and 1 means read. A receiver answers 0 for ACK and 1 for NACK.
- R4: A write sends the device address with direction 0. It then sends the memory address: high byte then low byte when `cmd_addr_two` is 1, or only the low byte otherwise. It then sends the data bytes and a stop. Each of these frames has its ACK checked.
- R5: A read sends the device address with direction 0 and the memory address. It then issues a repeated start with no stop in between, sends the device address with direction 1, and receives the data bytes. A read therefore has two starts and one stop.
- R6: During a read, the master pulls SDA low (ACK) in the acknowledge slot of every received byte except the last. For the last byte it leaves SDA released (NACK) and then sends a stop.
- R7: A `cmd_len` of 0 is treated as 1. A read longer than MAX_RD (default 32) bytes is cut to MAX_RD bytes.
- R8: A NACK sampled where an ACK is required sets `nack_err`, ends the transaction with a stop and returns to idle. `nack_err` stays set until the next command is accepted, and is cleared on acceptance.
- R9: The SCL period is 4*QTR_DIV system clock cycles: SCL is low for two quarters and high for two. SDA is set in the second low quarter and sampled at the middle of the high time.
- R10: A command is accepted only when `busy` is low. `cmd_valid` while busy is ignored and starts no bus activity.
- R11: `wr_req` is a one-cycle pulse, once per outgoing data byte, and `wr_data` is captured in that cycle. `rd_valid` is a one-cycle pulse, once per received byte, with the byte on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when not busy |
| cmd_read | input | 1 | 1 = random read, 0 = write |
| cmd_dev | input | 7 | Device address |
| cmd_addr_two | input | 1 | 1 = two-byte memory address |
| cmd_addr | input | 16 | Memory address (low byte only used in one-byte mode) |
| cmd_len | input | LEN_W | Byte count (0 means 1) |
| wr_data | input | 8 | Outgoing byte, valid while `wr_req` is high |
| wr_req | output | 1 | One-cycle request for the next outgoing byte |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | One-cycle strobe for `rd_data` |
| busy | output | 1 | Transaction in progress |
| nack_err | output | 1 | Sticky NACK error |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The hardest states to reach from the ports are the ones the slave decides: a NACK in the middle of a data burst, a refused device address, and the master's own ACK/NACK choice at the end of a read. The bench places a behavioural slave memory on the open-drain bus, built from SCL and SDA edges. That slave can be told to refuse any chosen frame, and it counts the acknowledge values the master drives. A read of 40 bytes drives the length cut. A command pulsed in the middle of a read covers the ignored-command case, and the bench confirms it by counting bus starts and stops.

// File: rtl/eei2c_pkg.sv
package eei2c_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_DEVW,
        ST_AHI,
        ST_ALO,
        ST_WDAT,
        ST_RSTART,
        ST_DEVR,
        ST_RDAT,
        ST_STOP
    } seq_st_e;

    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_START,
        SYM_STOP,
        SYM_BIT
    } sym_e;

endpackage

// File: rtl/eei2c_qtick.sv
module eei2c_qtick #(
    parameter int QTR_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (QTR_DIV > 2) ? $clog2(QTR_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || cnt_q == LAST) cnt_d = '0;
        else                      cnt_d = cnt_q + 1'b1;
    end

    assign tick = en && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eei2c_busdrv.sv
module eei2c_busdrv
    import eei2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  sym_e       sym,
    input  logic [1:0] qph,
    input  logic       pull,
    output logic       scl_oe,
    output logic       sda_oe
);
    typedef struct packed {
        logic scl;
        logic sda;
    } drv_t;

    drv_t d, q;

    always_comb begin
        d.scl = (sym != SYM_IDLE) && !qph[1];
        d.sda = q.sda;
        if (sym == SYM_IDLE) begin
            d.sda = 1'b0;
        end else if (qph != 2'd0) begin
            case (sym)
                SYM_START: d.sda = (qph == 2'd3);
                SYM_STOP:  d.sda = (qph != 2'd3);
                default:   d.sda = pull;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign scl_oe = q.scl;
    assign sda_oe = q.sda;
endmodule

// File: rtl/eei2c_seq.sv
module eei2c_seq
    import eei2c_pkg::*;
#(
    parameter int LEN_W  = 6,
    parameter int MAX_RD = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [6:0]       cmd_dev,
    input  logic             cmd_addr_two,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             sda_i,
    output logic             busy,
    output logic             nack_err,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             wr_req,
    output sym_e             sym,
    output logic [1:0]       qph,
    output logic             pull
);
    localparam logic [LEN_W-1:0] ONE   = LEN_W'(1);
    localparam logic [LEN_W-1:0] RDCAP = LEN_W'(MAX_RD);

    typedef struct packed {
        seq_st_e          st;
        logic [1:0]       qph;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic             smp;
        logic [LEN_W-1:0] rem;
        logic             rd;
        logic [6:0]       dev;
        logic             two;
        logic [15:0]      addr;
        logic             err;
        logic             rdv;
        logic [7:0]       rdd;
        logic             wrq;
    } seq_reg_t;

    seq_reg_t d, q;
    logic [LEN_W-1:0] eff_len;

    always_comb begin
        eff_len = (cmd_len == '0) ? ONE : cmd_len;
        if (cmd_read && eff_len > RDCAP) eff_len = RDCAP;
    end

    always_comb begin
        d     = q;
        d.rdv = 1'b0;
        d.wrq = 1'b0;
        if (q.wrq) d.sh = wr_data;
        if (q.st == ST_IDLE) begin
            if (cmd_valid) begin
                d.st   = ST_START;
                d.qph  = 2'd0;
                d.rd   = cmd_read;
                d.dev  = cmd_dev;
                d.two  = cmd_addr_two;
                d.addr = cmd_addr;
                d.rem  = eff_len;
                d.err  = 1'b0;
            end
        end else if (tick) begin
            d.qph = q.qph + 2'd1;
            if (q.qph == 2'd2) d.smp = sda_i;
            if (q.qph == 2'd3) begin
                case (q.st)
                    ST_START: begin
                        d.st = ST_DEVW; d.sh = {q.dev, 1'b0}; d.bitn = 4'd0;
                    end
                    ST_RSTART: begin
                        d.st = ST_DEVR; d.sh = {q.dev, 1'b1}; d.bitn = 4'd0;
                    end
                    ST_STOP: d.st = ST_IDLE;
                    default: begin
                        if (q.bitn != 4'd8) begin
                            d.bitn = q.bitn + 4'd1;
                            d.sh   = {q.sh[6:0], q.smp};
                            if (q.st == ST_RDAT && q.bitn == 4'd7) begin
                                d.rdv = 1'b1;
                                d.rdd = {q.sh[6:0], q.smp};
                            end
                        end else begin
                            d.bitn = 4'd0;
                            if (q.st != ST_RDAT && q.smp) begin
                                d.err = 1'b1;
                                d.st  = ST_STOP;
                            end else begin
                                case (q.st)
                                    ST_DEVW: begin
                                        d.st = q.two ? ST_AHI : ST_ALO;
                                        d.sh = q.two ? q.addr[15:8] : q.addr[7:0];
                                    end
                                    ST_AHI: begin
                                        d.st = ST_ALO; d.sh = q.addr[7:0];
                                    end
                                    ST_ALO: begin
                                        d.st  = q.rd ? ST_RSTART : ST_WDAT;
                                        d.wrq = !q.rd;
                                    end
                                    ST_WDAT: begin
                                        if (q.rem > ONE) begin
                                            d.rem = q.rem - ONE; d.wrq = 1'b1;
                                        end else d.st = ST_STOP;
                                    end
                                    ST_DEVR: d.st = ST_RDAT;
                                    ST_RDAT: begin
                                        if (q.rem > ONE) d.rem = q.rem - ONE;
                                        else             d.st  = ST_STOP;
                                    end
                                    default: d.st = ST_STOP;
                                endcase
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_comb begin
        case (q.st)
            ST_IDLE:             sym = SYM_IDLE;
            ST_START, ST_RSTART: sym = SYM_START;
            ST_STOP:             sym = SYM_STOP;
            default:             sym = SYM_BIT;
        endcase
        if (q.st == ST_RDAT) pull = (q.bitn == 4'd8) && (q.rem > ONE);
        else                 pull = (q.bitn != 4'd8) && !q.sh[7];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = (q.st != ST_IDLE);
    assign nack_err = q.err;
    assign rd_data  = q.rdd;
    assign rd_valid = q.rdv;
    assign wr_req   = q.wrq;
    assign qph      = q.qph;
endmodule

// File: rtl/eeprom_i2c_master.sv
module eeprom_i2c_master
    import eei2c_pkg::*;
#(
    parameter int QTR_DIV = 4,
    parameter int LEN_W   = 6,
    parameter int MAX_RD  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_read,
    input  logic [6:0]       cmd_dev,
    input  logic             cmd_addr_two,
    input  logic [15:0]      cmd_addr,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    output logic             wr_req,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    output logic             busy,
    output logic             nack_err,
    output logic             scl_oe,
    output logic             sda_oe,
    input  logic             sda_i
);
    logic       tick;
    sym_e       sym;
    logic [1:0] qph;
    logic       pull;

    eei2c_qtick #(.QTR_DIV(QTR_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
    );

    eei2c_seq #(.LEN_W(LEN_W), .MAX_RD(MAX_RD)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read), .cmd_dev(cmd_dev),
        .cmd_addr_two(cmd_addr_two), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
        .wr_data(wr_data), .sda_i(sda_i),
        .busy(busy), .nack_err(nack_err), .rd_data(rd_data),
        .rd_valid(rd_valid), .wr_req(wr_req),
        .sym(sym), .qph(qph), .pull(pull)
    );

    eei2c_busdrv u_drv (
        .clk(clk), .rst_n(rst_n), .sym(sym), .qph(qph), .pull(pull),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );
endmodule

// File: rtl/eei2c_master_chk.sv
module eei2c_master_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_valid,
    input logic busy,
    input logic nack_err,
    input logic rd_valid,
    input logic wr_req,
    input logic scl_oe,
    input logic sda_oe
);
    // R1: lines released whenever no transaction runs
    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!scl_oe && !sda_oe));

    // R10: a command seen while idle starts a transaction
    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R8: error flag holds until a command is accepted
    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_err && !(cmd_valid && !busy)) |=> nack_err);

    // R11: read strobe lasts one cycle and only inside a transaction
    a_r11_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    a_r11_rd_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    // R11: write request lasts one cycle and only inside a transaction
    a_r11_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |=> !wr_req);

    a_r11_wr_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> busy);
endmodule

bind eeprom_i2c_master eei2c_master_chk u_chk (.*);

// File: tb/tb_eeprom_i2c_master.sv
module tb_eeprom_i2c_master;
    localparam int CLK_PER = 10;
    localparam int QTR     = 4;
    localparam logic [6:0] SLV_DEV = 7'h50;

    typedef struct packed {
        logic        rd;
        logic [6:0]  dev;
        logic        two;
        logic [15:0] addr;
        logic [5:0]  len;
        logic [7:0]  seed;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 7'h50, 1'b0, 16'h0010, 6'd4, 8'hA1},
        '{1'b1, 7'h50, 1'b0, 16'h0010, 6'd4, 8'h00},
        '{1'b0, 7'h50, 1'b1, 16'h3CF0, 6'd3, 8'h37},
        '{1'b1, 7'h50, 1'b1, 16'h3CEF, 6'd5, 8'h00},
        '{1'b1, 7'h50, 1'b0, 16'h0000, 6'd1, 8'h00},
        '{1'b0, 7'h50, 1'b0, 16'h00FE, 6'd1, 8'h5C}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0, cmd_read = 1'b0, cmd_addr_two = 1'b0;
    logic [6:0]  cmd_dev = '0;
    logic [15:0] cmd_addr = '0;
    logic [5:0]  cmd_len = '0;
    logic [7:0]  wr_data;
    logic wr_req, rd_valid, busy, nack_err, scl_oe, sda_oe, sda_i;
    logic [7:0] rd_data;

    always #(CLK_PER/2) clk = ~clk;

    eeprom_i2c_master #(.QTR_DIV(QTR), .LEN_W(6), .MAX_RD(32)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .cmd_dev(cmd_dev), .cmd_addr_two(cmd_addr_two), .cmd_addr(cmd_addr),
        .cmd_len(cmd_len), .wr_data(wr_data), .wr_req(wr_req),
        .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
        .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_i(sda_i)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // write data source and read capture
    logic [7:0] wdat [64];
    logic [7:0] rbuf [64];
    int widx = 0, wbase = 0, rcnt = 0, rbase = 0;
    assign wr_data = wdat[(widx - wbase) & 63];
    always @(posedge clk) if (wr_req) widx <= widx + 1;
    always @(negedge clk) if (rd_valid) begin
        rbuf[(rcnt - rbase) & 63] = rd_data;
        rcnt = rcnt + 1;
    end

    // behavioural slave memory on the open-drain bus
    logic [7:0] smem [256];
    logic [7:0] shadow [256];
    logic s_pull = 1'b0;
    wire  scl_b = ~scl_oe;
    wire  sda_b = ~sda_oe & ~s_pull;
    assign sda_i = sda_b;

    logic s_two = 1'b0;
    int   s_nack_at = 255;
    int   s_bitc = 0, s_bidx = 0, s_starts = 0, s_stops = 0;
    int   s_macks = 0, s_mnacks = 0, s_nper = 0, s_badper = 0, lastrise = 0;
    logic s_tx = 1'b0, s_pend = 1'b0, s_sendn = 1'b0, s_addr_ok = 1'b0;
    logic [7:0] s_sh = '0, s_ptr = '0, s_hi = '0;
    logic pscl = 1'b1, psda = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            pscl = 1'b1; psda = 1'b1;
        end else begin
            if (pscl && scl_b && psda && !sda_b) begin
                s_starts++; s_bitc = 0; s_bidx = 0; s_tx = 0; s_pend = 0;
                s_pull = 0; s_addr_ok = 0;
            end else if (pscl && scl_b && !psda && sda_b) begin
                s_stops++; s_tx = 0; s_pend = 0; s_pull = 0; s_bitc = 0;
            end else if (!pscl && scl_b) begin
                if (s_bitc >= 1 && s_bitc <= 8) begin
                    s_nper++;
                    if (cyc - lastrise != 4*QTR) s_badper++;
                end
                lastrise = cyc;
                if (s_bitc < 8) begin
                    if (!s_tx) s_sh = {s_sh[6:0], sda_b};
                end else if (s_tx) begin
                    if (sda_b) s_mnacks++; else s_macks++;
                    s_sendn = !sda_b;
                end
                s_bitc++;
            end else if (pscl && !scl_b) begin
                if (s_bitc == 8) begin
                    if (!s_tx) begin
                        if (s_bidx == 0) begin
                            s_addr_ok = (s_sh[7:1] == SLV_DEV);
                            if (s_addr_ok && s_sh[0]) s_pend = 1;
                        end else if (s_addr_ok) begin
                            if (s_two && s_bidx == 1) s_hi = s_sh;
                            else if (s_bidx == (s_two ? 2 : 1)) s_ptr = s_sh;
                            else begin smem[s_ptr] = s_sh; s_ptr++; end
                        end
                        s_pull = s_addr_ok && (s_bidx != s_nack_at);
                        s_bidx++;
                    end else s_pull = 0;
                end else if (s_bitc == 9) begin
                    s_bitc = 0; s_pull = 0;
                    if (s_pend) begin s_tx = 1; s_pend = 0; s_sendn = 1; end
                    if (s_tx && s_sendn) begin
                        s_sh = smem[s_ptr]; s_ptr++; s_pull = ~s_sh[7];
                    end
                end else if (s_tx && s_bitc >= 1) begin
                    s_pull = ~s_sh[7 - s_bitc];
                end
            end
            pscl = scl_b; psda = sda_b;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int b_starts, b_stops, b_macks, b_mnacks;
    task automatic snap();
        b_starts = s_starts; b_stops = s_stops;
        b_macks = s_macks; b_mnacks = s_mnacks;
        wbase = widx; rbase = rcnt;
    endtask

    task automatic issue(input logic rd, input logic [6:0] dev, input logic two,
                         input logic [15:0] addr, input logic [5:0] len);
        @(negedge clk);
        cmd_read = rd; cmd_dev = dev; cmd_addr_two = two;
        cmd_addr = addr; cmd_len = len; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 30000) begin @(negedge clk); t++; end
        if (t >= 30000) chk("R2 transaction ends", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic fill_wdat(input logic [7:0] seed);
        for (int i = 0; i < 64; i++) wdat[i] = seed + 8'(i * 29);
    endtask

    task automatic check_read(input string tag, input logic [7:0] lo, input int n);
        int bad = 0;
        chk({tag, " R7 byte count"}, rcnt - rbase, n);
        for (int i = 0; i < n; i++)
            if (rbuf[i] !== shadow[8'(lo + 8'(i))]) bad++;
        chk({tag, " R5 R3 data mismatches"}, bad, 0);
        chk({tag, " R5 starts"}, s_starts - b_starts, 2);
        chk({tag, " R2 stops"}, s_stops - b_stops, 1);
        chk({tag, " R6 master acks"}, s_macks - b_macks, n - 1);
        chk({tag, " R6 master nacks"}, s_mnacks - b_mnacks, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            smem[i] = 8'(i) ^ 8'h5A;
            shadow[i] = 8'(i) ^ 8'h5A;
        end
        fill_wdat(8'h00);
        repeat (5) @(negedge clk);
        // R1: reset state
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 nack_err", int'(nack_err), 0);
        chk("R11 rd_valid reset", int'(rd_valid), 0);
        chk("R11 wr_req reset", int'(wr_req), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // table walk
        for (int v = 0; v < NV; v++) begin
            s_two = VECS[v].two; s_nack_at = 255;
            if (!VECS[v].rd) fill_wdat(VECS[v].seed);
            snap();
            issue(VECS[v].rd, VECS[v].dev, VECS[v].two, VECS[v].addr, VECS[v].len);
            wait_idle();
            chk("R8 no error", int'(nack_err), 0);
            chk("R1 idle released", int'(scl_oe | sda_oe), 0);
            if (VECS[v].rd) begin
                check_read("vec", VECS[v].addr[7:0], int'(VECS[v].len));
            end else begin
                int bad = 0;
                for (int i = 0; i < int'(VECS[v].len); i++) begin
                    shadow[8'(VECS[v].addr[7:0] + 8'(i))] = wdat[i];
                    if (smem[8'(VECS[v].addr[7:0] + 8'(i))] !== wdat[i]) bad++;
                end
                chk("R11 write requests", widx - wbase, int'(VECS[v].len));
                chk("R4 R3 written bytes mismatches", bad, 0);
                chk("R4 starts", s_starts - b_starts, 1);
                chk("R2 stops", s_stops - b_stops, 1);
                if (VECS[v].two) chk("R4 high address byte", int'(s_hi), int'(VECS[v].addr[15:8]));
            end
        end

        // R9: SCL period measured by the slave
        chk("R9 bad periods", s_badper, 0);
        chk("R9 periods seen", int'(s_nper > 100), 1);

        // R7: zero length read gives one byte
        s_two = 1'b0; snap();
        issue(1'b1, SLV_DEV, 1'b0, 16'h0010, 6'd0);
        wait_idle();
        check_read("len0", 8'h10, 1);

        // R7: long read cut to 32 bytes
        snap();
        issue(1'b1, SLV_DEV, 1'b0, 16'h0000, 6'd40);
        wait_idle();
        check_read("len40", 8'h00, 32);

        // R8: wrong device address refused
        snap();
        issue(1'b0, 7'h23, 1'b0, 16'h0020, 6'd2);
        wait_idle();
        chk("R8 err on address nack", int'(nack_err), 1);
        chk("R8 no write requests", widx - wbase, 0);
        chk("R8 stop sent", s_stops - b_stops, 1);
        chk("R8 back to idle", int'(busy), 0);
        repeat (100) @(negedge clk);
        chk("R8 err sticky", int'(nack_err), 1);
        snap();
        issue(1'b1, SLV_DEV, 1'b0, 16'h0010, 6'd1);
        chk("R8 err cleared on accept", int'(nack_err), 0);
        wait_idle();

        // R8: nack on second data byte
        fill_wdat(8'h11); snap(); s_nack_at = 3;
        issue(1'b0, SLV_DEV, 1'b0, 16'h0080, 6'd4);
        wait_idle();
        s_nack_at = 255;
        chk("R8 err on data nack", int'(nack_err), 1);
        chk("R8 requests before nack", widx - wbase, 2);
        chk("R8 single stop", s_stops - b_stops, 1);

        // R10: command while busy is ignored
        snap();
        issue(1'b1, SLV_DEV, 1'b0, 16'h0010, 6'd2);
        repeat (50) @(negedge clk);
        cmd_read = 1'b0; cmd_dev = SLV_DEV; cmd_len = 6'd1; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        wait_idle();
        repeat (200) @(negedge clk);
        chk("R10 still idle", int'(busy), 0);
        chk("R10 starts", s_starts - b_starts, 2);
        chk("R10 stops", s_stops - b_stops, 1);
        chk("R10 no write requests", widx - wbase, 0);
        chk("R10 read count", rcnt - rbase, 2);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule